// File: doc/BRIEF.md
# Foldable Double SHA-256 Work-Unit Hasher

This block hashes one block-header work unit twice with SHA-256. A precomputed midstate covers the first 64 bytes of the header. The block takes that midstate, the three remaining header words and a candidate nonce. It builds the padded final chunk and compresses it from the midstate. It then hashes the 256-bit digest that results with a second SHA-256 compression that starts from the standard initial value. The block returns the final hash and the nonce that produced it, together with a single-cycle valid strobe. It also returns a flag that is high when the leading bits of the last hash word are zero.

Each engine is a chain of registered round stages, and a generate loop builds the chain. The parameter `LOOP_LOG2` folds each engine. A build with 2^LOOP_LOG2 passes has 64/2^LOOP_LOG2 physical stages. Each stage runs its rounds by feeding its own result back to its input multiplexer, and it hands the item to the next stage once every 2^LOOP_LOG2 cycles. A new nonce can enter in the cycle in which the first stage is free. The unfolded build (`LOOP_LOG2` = 0) has no feedback multiplexers. It drops the last three rounds of the second hash and produces only the final hash word, which is the one a difficulty test reads.

Top module: `dsha_fold_pipe`

## Requirements
- R1: When `LOOP_LOG2` > 0, `hash_o` is the standard SHA-256 compression of a second chunk, taken from the standard initial value. That second chunk holds the first compression's digest, where the first compression starts from `midstate_i`. Hash word j (j = 0..7, word 0 is the first state word) sits at bits [255-32j -: 32]. `midstate_i` uses the same packing.
- R2: The first chunk is made of `tail_i[95:64]`, `tail_i[63:32]`, `tail_i[31:0]` and `nonce_i`, followed by 32'h80000000, ten zero words and 32'h00000280. The second chunk is made of the eight digest words, followed by 32'h80000000, six zero words and 32'h00000100.
- R3: After reset, `in_ready_o` is high in the first cycle and then once in every 2^LOOP_LOG2 cycles. An input is taken only in a cycle where both `in_valid_i` and `in_ready_o` are high. Inputs in every other cycle have no effect on any output.
- R4: `valid_o` rises after exactly 128 clock edges, counted from the edge that took the input. In the `LOOP_LOG2` = 0 build it rises after 125 edges.
- R5: `nonce_o` shows the nonce of the input that produced the hash shown in the same cycle.
- R6: In the `LOOP_LOG2` = 0 build, `hash_o[31:0]` holds the correct final word 7 and `hash_o[255:32]` reads zero.
- R7: `golden_o` is high together with `valid_o` exactly when the top `ZERO_BITS` bits of hash word 7 are zero.
- R8: The active-low asynchronous reset clears every item in flight and the fold phase. No result appears until a new input is taken, and `in_ready_o` is high in the first cycle after reset.
- R9: Results leave in the order their inputs were taken, and `valid_o` is a one-cycle pulse. In folded builds, `hash_o` and `nonce_o` hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Work unit offered |
| midstate_i | input | 256 | SHA-256 state after the first header chunk |
| tail_i | input | 96 | The three header words that follow the midstate |
| nonce_i | input | 32 | Candidate nonce |
| in_ready_o | output | 1 | First stage free in this cycle |
| valid_o | output | 1 | Result strobe |
| hash_o | output | 256 | Double-hash result |
| nonce_o | output | 32 | Nonce that produced `hash_o` |
| golden_o | output | 1 | Leading bits of hash word 7 are zero |

## Verification
The zero-word flag is the hardest behaviour to reach from the ports, because random work units almost never give a zero top word. The bench therefore builds every instance with `ZERO_BITS` set to 4, so about one result in sixteen raises the flag and both outcomes are checked against the bench's own double hash. The next hardest case is a reset taken while the folded chains are full and recirculating. The bench streams back-to-back inputs and pulls reset in the middle of the stream. It then confirms that no stale result leaves and that a fresh input after reset still returns with the correct latency. Three builds (fold 0, 1 and 2) share one stimulus stream. Each build therefore also meets inputs that change on the cycles when it is not ready.

// File: rtl/dsha_pkg.sv
package dsha_pkg;

  typedef logic [31:0] word_t;

  typedef struct packed {
    logic          vld;
    word_t         tag;
    word_t [7:0]   st;   // a..h at index 0..7
    word_t [7:0]   ff;   // feed-forward value
    word_t [15:0]  w;    // schedule window, w[0] used this round
  } slot_t;

  localparam word_t IV [8] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam word_t RC [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic word_t rotr(word_t x, int unsigned n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic word_t big_s0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  // one round plus one schedule step
  function automatic slot_t round_step(slot_t s, word_t k);
    slot_t r;
    word_t t1, t2, chv, mjv;
    chv = (s.st[4] & s.st[5]) ^ (~s.st[4] & s.st[6]);
    mjv = (s.st[0] & s.st[1]) ^ (s.st[0] & s.st[2]) ^ (s.st[1] & s.st[2]);
    t1  = s.st[7] + big_s1(s.st[4]) + chv + k + s.w[0];
    t2  = big_s0(s.st[0]) + mjv;
    r = s;
    r.st[7] = s.st[6];
    r.st[6] = s.st[5];
    r.st[5] = s.st[4];
    r.st[4] = s.st[3] + t1;
    r.st[3] = s.st[2];
    r.st[2] = s.st[1];
    r.st[1] = s.st[0];
    r.st[0] = t1 + t2;
    for (int i = 0; i < 15; i++) r.w[i] = s.w[i+1];
    r.w[15] = sml_s1(s.w[14]) + s.w[9] + sml_s0(s.w[1]) + s.w[0];
    return r;
  endfunction

endpackage

// File: rtl/sha_fold_stage.sv
module sha_fold_stage
  import dsha_pkg::*;
#(
  parameter int unsigned LOG  = 0,
  parameter int unsigned PW   = 1,
  parameter int unsigned BASE = 0
)(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] phase_i,
  input  slot_t         prev_i,
  output slot_t         slot_o
);

  slot_t     slot_q, src, nxt;
  logic [5:0] ridx;

  generate
    if (LOG == 0) begin : g_flat
      assign src = prev_i;
    end else begin : g_fold
      // take a new item on phase 0, otherwise recirculate
      assign src = (phase_i == '0) ? prev_i : slot_q;
    end
  endgenerate

  assign ridx = 6'(BASE) + 6'(phase_i);
  assign nxt  = round_step(src, RC[ridx]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= nxt;
  end

  assign slot_o = slot_q;

endmodule

// File: rtl/sha_fold_engine.sv
module sha_fold_engine
  import dsha_pkg::*;
#(
  parameter int unsigned LOG  = 0,
  parameter int unsigned PW   = 1,
  parameter int unsigned NSTG = 64
)(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] phase_i,
  input  slot_t         head_i,
  output slot_t         tail_o
);

  localparam int unsigned FOLD = 1 << LOG;

  slot_t chain [NSTG+1];

  assign chain[0] = head_i;

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    sha_fold_stage #(
      .LOG (LOG),
      .PW  (PW),
      .BASE(i * FOLD)
    ) u_stg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .phase_i(phase_i),
      .prev_i (chain[i]),
      .slot_o (chain[i+1])
    );
  end

  assign tail_o = chain[NSTG];

endmodule

// File: rtl/dsha_fold_pipe.sv
module dsha_fold_pipe
  import dsha_pkg::*;
#(
  parameter int unsigned LOOP_LOG2 = 0,
  parameter int unsigned ZERO_BITS = 32
)(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [255:0] midstate_i,
  input  logic [95:0]  tail_i,
  input  logic [31:0]  nonce_i,
  output logic         in_ready_o,
  output logic         valid_o,
  output logic [255:0] hash_o,
  output logic [31:0]  nonce_o,
  output logic         golden_o
);

  localparam int unsigned FOLD = 1 << LOOP_LOG2;
  localparam int unsigned PW   = (LOOP_LOG2 == 0) ? 1 : LOOP_LOG2;
  localparam bit          TRIM = (LOOP_LOG2 == 0);
  localparam int unsigned STG1 = 64 / FOLD;
  localparam int unsigned STG2 = TRIM ? 61 : STG1;

  logic [PW-1:0] phase_q;
  slot_t         head1, tail1, head2, tail2;
  logic [255:0]  res;
  logic          zero_hit;
  logic          valid_q, golden_q;
  logic [255:0]  hash_q;
  logic [31:0]   nonce_q;
  logic          unused_bits;

  generate
    if (LOOP_LOG2 == 0) begin : g_nophase
      assign phase_q = '0;
    end else begin : g_phase
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= '0;
        else         phase_q <= phase_q + 1'b1;
      end
    end
  endgenerate

  assign in_ready_o = (phase_q == '0);

  always_comb begin
    head1     = '0;
    head1.vld = in_valid_i & in_ready_o;
    head1.tag = nonce_i;
    for (int j = 0; j < 8; j++) begin
      head1.st[j] = midstate_i[255-32*j -: 32];
      head1.ff[j] = midstate_i[255-32*j -: 32];
    end
    for (int j = 0; j < 3; j++) head1.w[j] = tail_i[95-32*j -: 32];
    head1.w[3]  = nonce_i;
    head1.w[4]  = 32'h8000_0000;
    head1.w[15] = 32'h0000_0280;
  end

  sha_fold_engine #(.LOG(LOOP_LOG2), .PW(PW), .NSTG(STG1)) u_eng1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(phase_q),
    .head_i (head1),
    .tail_o (tail1)
  );

  always_comb begin
    head2     = '0;
    head2.vld = tail1.vld;
    head2.tag = tail1.tag;
    for (int j = 0; j < 8; j++) begin
      head2.st[j] = IV[j];
      head2.ff[j] = IV[j];
      head2.w[j]  = tail1.ff[j] + tail1.st[j];
    end
    head2.w[8]  = 32'h8000_0000;
    head2.w[15] = 32'h0000_0100;
  end

  sha_fold_engine #(.LOG(LOOP_LOG2), .PW(PW), .NSTG(STG2)) u_eng2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(phase_q),
    .head_i (head2),
    .tail_o (tail2)
  );

  always_comb begin
    res = '0;
    if (TRIM) begin
      // after round 60, e becomes h three rounds later
      res[31:0] = IV[7] + tail2.st[4];
    end else begin
      for (int j = 0; j < 8; j++) res[255-32*j -: 32] = IV[j] + tail2.st[j];
    end
  end

  assign zero_hit = (res[31 -: ZERO_BITS] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      golden_q <= 1'b0;
      hash_q   <= '0;
      nonce_q  <= '0;
    end else if (phase_q == '0) begin
      valid_q  <= tail2.vld;
      golden_q <= tail2.vld & zero_hit;
      hash_q   <= res;
      nonce_q  <= tail2.tag;
    end else begin
      valid_q  <= 1'b0;
      golden_q <= 1'b0;
    end
  end

  assign valid_o  = valid_q;
  assign golden_o = golden_q;
  assign hash_o   = hash_q;
  assign nonce_o  = nonce_q;

  assign unused_bits = ^{tail1.w, tail2.w, tail2.ff, tail2.st};

endmodule

// File: rtl/dsha_fold_chk.sv
module dsha_fold_chk #(
  parameter int unsigned LOOP_LOG2 = 0,
  parameter int unsigned ZERO_BITS = 32
)(
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_ready_o,
  input logic         valid_o,
  input logic [255:0] hash_o,
  input logic [31:0]  nonce_o,
  input logic         golden_o
);

  localparam bit          TRIM = (LOOP_LOG2 == 0);
  localparam int unsigned LAT  = TRIM ? 125 : 128;

  logic [7:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_q <= '0;
    else if (since_q != 8'hFF) since_q <= since_q + 8'd1;
  end

  assert_ready_after_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_q == 8'd0 |-> in_ready_o);

  assert_lat_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> since_q >= 8'(LAT));

  assert_golden_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    golden_o |-> valid_o && (hash_o[31 -: ZERO_BITS] == '0));

  generate
    if (TRIM) begin : g_flat
      assert_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_ready_o);
      assert_trim_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> hash_o[255:32] == '0);
    end else begin : g_fold
      assert_ready_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_ready_o |=> !in_ready_o);
      assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);
      assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_ready_o |=> $stable(hash_o) && $stable(nonce_o));
    end
  endgenerate

endmodule

bind dsha_fold_pipe dsha_fold_chk #(
  .LOOP_LOG2(LOOP_LOG2),
  .ZERO_BITS(ZERO_BITS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_ready_o(in_ready_o),
  .valid_o   (valid_o),
  .hash_o    (hash_o),
  .nonce_o   (nonce_o),
  .golden_o  (golden_o)
);

// File: tb/dsha_fold_pipe_tb_top.sv
module dsha_fold_pipe_tb_top;
  import dsha_pkg::RC;
  import dsha_pkg::IV;

  localparam int ZB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int edge_n = 0;
  int rel = 0;
  bit done = 0;

  logic         in_vld = 1'b0;
  logic [255:0] mid = '0;
  logic [95:0]  tl = '0;
  logic [31:0]  non = '0;

  typedef struct {
    int           acc;
    logic [31:0]  non;
    logic [255:0] hsh;
  } exp_t;

  always @(posedge clk) edge_n <= edge_n + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_compress(logic [255:0] init, logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    logic [255:0] out;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int j = 0; j < 8; j++) v[j] = init[255-32*j -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + RC[t] + w[t];
      t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int j = 7; j > 0; j--) v[j] = v[j-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    for (int j = 0; j < 8; j++) out[255-32*j -: 32] = init[255-32*j -: 32] + v[j];
    return out;
  endfunction

  function automatic logic [255:0] iv_packed();
    logic [255:0] p;
    for (int j = 0; j < 8; j++) p[255-32*j -: 32] = IV[j];
    return p;
  endfunction

  function automatic logic [255:0] ref_dsha(logic [255:0] m, logic [95:0] t, logic [31:0] n);
    logic [255:0] d;
    d = ref_compress(m, {t, n, 32'h8000_0000, 320'b0, 32'h0000_0280});
    return ref_compress(iv_packed(), {d, 32'h8000_0000, 192'b0, 32'h0000_0100});
  endfunction

  for (genvar g = 0; g < 3; g++) begin : g_fold
    localparam int LAT = (g == 0) ? 125 : 128;
    localparam int P   = 1 << g;
    logic         rdy, vo, go;
    logic [255:0] ho;
    logic [31:0]  no;
    logic         prev_vo = 1'b0;
    int           golds = 0;
    exp_t         q [$];

    dsha_fold_pipe #(.LOOP_LOG2(g), .ZERO_BITS(ZB)) dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .in_valid_i(in_vld),
      .midstate_i(mid),
      .tail_i    (tl),
      .nonce_i   (non),
      .in_ready_o(rdy),
      .valid_o   (vo),
      .hash_o    (ho),
      .nonce_o   (no),
      .golden_o  (go)
    );

    always @(negedge clk) begin
      exp_t         e;
      logic [255:0] eh;
      #1;
      if (!done) begin
        if (!rst_n) begin
          q.delete();
          check(rdy === 1'b1, "R8", "ready in reset", {255'b0, rdy}, 256'd1);
          check(vo === 1'b0, "R8", "valid in reset", {255'b0, vo}, 256'd0);
          prev_vo = 1'b0;
        end else begin
          // R3: ready pattern from the fold phase
          check(rdy === (((edge_n - rel) % P) == 0), "R3", "ready phase",
                {255'b0, rdy}, {255'b0, (((edge_n - rel) % P) == 0)});
          if (in_vld && rdy) begin
            e.acc = edge_n + 1;
            e.non = non;
            e.hsh = ref_dsha(mid, tl, non);
            q.push_back(e);
          end
          if (vo) begin
            if (q.size() == 0) begin
              check(1'b0, "R8", "result with nothing pending", {224'b0, no}, '0);
            end else begin
              e = q.pop_front();
              check(edge_n == e.acc + LAT, "R4", "latency",
                    256'(edge_n), 256'(e.acc + LAT));
              check(no === e.non, "R5", "nonce", {224'b0, no}, {224'b0, e.non});
              if (g == 0) begin
                eh = {224'b0, e.hsh[31:0]};
                check(ho === eh, "R6", "trimmed hash", ho, eh);
              end else begin
                eh = e.hsh;
                check(ho === eh, "R1 R2", "double hash", ho, eh);
              end
              check(go === (e.hsh[31 -: ZB] == '0), "R7", "golden flag",
                    {255'b0, go}, {255'b0, (e.hsh[31 -: ZB] == '0)});
              if (go) golds++;
              if (g > 0) check(!prev_vo, "R9", "single-cycle strobe",
                               {255'b0, prev_vo}, 256'd0);
            end
          end else begin
            check(go === 1'b0, "R7", "golden without valid", {255'b0, go}, 256'd0);
          end
          prev_vo = vo;
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic drive(input logic v, input logic [255:0] m, input logic [95:0] t,
                       input logic [31:0] n);
    @(negedge clk);
    in_vld = v; mid = m; tl = t; non = n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=done", edge_n);
    finish_run();
  end

  initial begin
    int seed;
    logic [255:0] abc;
    seed = $urandom(32'd2024);
    abc = ref_compress(iv_packed(), {32'h6162_6380, 448'b0, 32'h0000_0018});
    check(abc == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
          "R1", "bench reference on abc", abc,
          256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);

    repeat (3) @(negedge clk);
    rel = edge_n;
    rst_n = 1'b1;

    // directed: all-zero and all-ones work units, held four cycles
    for (int k = 0; k < 4; k++) drive(1'b1, iv_packed(), '0, '0);
    for (int k = 0; k < 4; k++) drive(1'b1, {8{32'hffff_ffff}}, {3{32'hffff_ffff}}, 32'hffff_ffff);
    drive(1'b0, '0, '0, '0);

    // back-to-back stream, data changes every cycle (R3 ignored slots)
    for (int k = 0; k < 60; k++)
      drive(1'b1, {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom}, 32'h1000_0000 + k);

    // sparse random offers
    for (int k = 0; k < 80; k++)
      drive(1'($urandom % 2), {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom}, $urandom);
    drive(1'b0, '0, '0, '0);
    repeat (140) @(negedge clk);

    // R8: reset while the chains are full
    for (int k = 0; k < 40; k++)
      drive(1'b1, {8{$urandom}}, {3{$urandom}}, 32'h2000_0000 + k);
    rst_n = 1'b0;
    in_vld = 1'b0;
    repeat (3) @(negedge clk);
    rel = edge_n;
    rst_n = 1'b1;
    repeat (140) @(negedge clk);

    // recovery after reset
    for (int k = 0; k < 8; k++)
      drive(1'b1, {8{$urandom}}, {3{$urandom}}, 32'h3000_0000 + k);
    drive(1'b0, '0, '0, '0);
    repeat (140) @(negedge clk);

    check(g_fold[0].q.size() == 0, "R9", "fold0 pending left", 256'(g_fold[0].q.size()), '0);
    check(g_fold[1].q.size() == 0, "R9", "fold1 pending left", 256'(g_fold[1].q.size()), '0);
    check(g_fold[2].q.size() == 0, "R9", "fold2 pending left", 256'(g_fold[2].q.size()), '0);
    $display("golden hits %0d %0d %0d", g_fold[0].golds, g_fold[1].golds, g_fold[2].golds);
    finish_run();
  end

endmodule